// File: doc/BRIEF.md
# 10 Mb/s Transmit Jabber Guard

This block sits beside the transmit path of a 10/100 twisted-pair PHY. It watches the transmit-enable request from the MAC and decides when a transmission has run on too long. In 10 Mb/s mode, a single unbroken transmission longer than `JAB_LIMIT_CYC` clock cycles is a jabber condition. The guard then holds the line transmitter idle, drives collision back toward the MAC, and raises two status flags. One flag is live and follows the condition. The other is sticky and stays set until a status read clears it.

The condition ends only after transmit enable has been low for `RELEASE_CYC` consecutive cycles. Any high cycle during that quiet period restarts it. In 100 Mb/s mode, or while the disable input is high, the guard stays inert: counts are cleared and any jabber in progress ends at once. By default the limit is about 20 ms and the quiet period about 0.5 s at a 25 MHz clock. Both are given in cycles.

The controller has three named states:
- `ST_IDLE`: transmit enable is low.
- `ST_SEND`: a transmission is being timed.
- `ST_JAB`: the transmitter is cut off.

The transitions are:
- IDLE→SEND: transmit enable is sampled high.
- SEND→IDLE: transmit enable is sampled low.
- SEND→JAB: the trip edge, where enable is high with the run count already at the limit.
- JAB→IDLE: the release edge, where the quiet count completes.
- any→IDLE: the guard becomes inactive.

Top module: `tx_jabber_guard`

## Requirements
- R1: While reset is asserted and after it, with no stimulus, `tx_gate_o`, `col_o`, `jab_live_o` and `jab_latched_o` are all 0.
- R2: In 10 Mb/s mode with detection enabled, `tx_en_i` sampled high on `JAB_LIMIT_CYC` consecutive edges causes no jabber. The next consecutive high edge enters jabber, and `jab_live_o` is 1 right after that edge.
- R3: A single low sample on `tx_en_i` ends a transmission, so high runs separated by a low cycle never add up toward the limit.
- R4: While `jab_live_o` is 1, `tx_gate_o` is 0 whatever `tx_en_i` does. Otherwise `tx_gate_o` equals `tx_en_i`.
- R5: `col_o` is 1 exactly while `jab_live_o` is 1.
- R6: `jab_latched_o` becomes 1 on the edge that enters jabber, even if `stat_rd_i` is high on that edge. It stays 1 until an edge with `stat_rd_i` high and no new entry, after which it is 0.
- R7: With `speed_10_i` = 0 (100 Mb/s), jabber is never entered. An ongoing jabber ends on the next edge. After a return to 10 Mb/s, timing starts from zero.
- R8: With `jab_off_i` = 1, jabber is never entered and an ongoing jabber ends on the next edge.
- R9: In jabber, `jab_live_o` clears on the `RELEASE_CYC`-th consecutive edge with `tx_en_i` low. A high sample restarts that count.
- R10: `stat_rd_i` has no effect on `jab_live_o` or `col_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit-enable request from the MAC |
| speed_10_i | input | 1 | 1 = 10 Mb/s mode, 0 = 100 Mb/s mode |
| jab_off_i | input | 1 | 1 = jabber detection disabled |
| stat_rd_i | input | 1 | Status-read strobe; clears the sticky flag |
| tx_gate_o | output | 1 | Transmit enable toward the line driver |
| col_o | output | 1 | Collision indication toward the MAC |
| jab_live_o | output | 1 | Live jabber status |
| jab_latched_o | output | 1 | Sticky jabber status |

## Verification
The properties assume that the inputs are sampled synchronously to `clk`. They also assume that mode and disable changes take effect on the edge after they are observed, so the checks on inert behaviour look one edge ahead. The property on staying in jabber under a read takes for granted that transmit enable is held high, which keeps the quiet count from completing on that edge. The bench changes every input only on the falling clock edge and sweeps burst lengths and quiet-period interruptions over a small configuration, `JAB_LIMIT_CYC` = 8 and `RELEASE_CYC` = 5. Each expected value comes from cycle arithmetic on those two numbers.

// File: rtl/jab_pkg.sv
package jab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_JAB  = 2'd2
    } jab_state_t;
endpackage

// File: rtl/jab_span_counter.sv
// Saturating run-length counter with synchronous clear.
module jab_span_counter #(
    parameter int unsigned MAX = 8,
    localparam int unsigned W = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = W'(MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/jab_ctrl_fsm.sv
module jab_ctrl_fsm
    import jab_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       tx_en,
    input  logic       run_full,
    input  logic       quiet_full,
    input  logic       stat_rd,
    output jab_state_t state,
    output logic       tx_gate,
    output logic       col,
    output logic       jab_live,
    output logic       jab_sticky
);
    jab_state_t nxt;
    logic       entry;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (tx_en) nxt = ST_SEND;
                ST_SEND: begin
                    if (!tx_en)        nxt = ST_IDLE;
                    else if (run_full) nxt = ST_JAB;
                end
                ST_JAB:  if (quiet_full) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    assign entry = (state == ST_SEND) && (nxt == ST_JAB);

    // Sticky status: a new entry wins over a read on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       jab_sticky <= 1'b0;
        else if (entry)   jab_sticky <= 1'b1;
        else if (stat_rd) jab_sticky <= 1'b0;
    end

    // Outputs
    always_comb begin
        jab_live = (state == ST_JAB);
        col      = jab_live;
        tx_gate  = tx_en && !jab_live;
    end
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
    import jab_pkg::*;
#(
    parameter int unsigned JAB_LIMIT_CYC = 500_000,
    parameter int unsigned RELEASE_CYC   = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic speed_10_i,
    input  logic jab_off_i,
    input  logic stat_rd_i,
    output logic tx_gate_o,
    output logic col_o,
    output logic jab_live_o,
    output logic jab_latched_o
);
    localparam int unsigned RW = $clog2(JAB_LIMIT_CYC + 1);
    localparam int unsigned QW = $clog2(RELEASE_CYC + 1);
    localparam logic [RW-1:0] RUN_TOP  = RW'(JAB_LIMIT_CYC);
    localparam logic [QW-1:0] QUIET_LAST = QW'(RELEASE_CYC - 1);

    jab_state_t    state;
    logic          active;
    logic [RW-1:0] run_cnt;
    logic [QW-1:0] quiet_cnt;
    logic          run_full;
    logic          quiet_full;

    assign active = speed_10_i && !jab_off_i;

    jab_span_counter #(.MAX(JAB_LIMIT_CYC)) run_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!active || !tx_en_i || state == ST_JAB),
        .inc   (tx_en_i),
        .cnt   (run_cnt)
    );

    jab_span_counter #(.MAX(RELEASE_CYC)) quiet_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!active || tx_en_i || state != ST_JAB),
        .inc   (!tx_en_i),
        .cnt   (quiet_cnt)
    );

    assign run_full   = tx_en_i && (run_cnt == RUN_TOP);
    assign quiet_full = (state == ST_JAB) && !tx_en_i && (quiet_cnt == QUIET_LAST);

    jab_ctrl_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .tx_en      (tx_en_i),
        .run_full   (run_full),
        .quiet_full (quiet_full),
        .stat_rd    (stat_rd_i),
        .state      (state),
        .tx_gate    (tx_gate_o),
        .col        (col_o),
        .jab_live   (jab_live_o),
        .jab_sticky (jab_latched_o)
    );
endmodule

// File: rtl/tx_jabber_guard_chk.sv
module tx_jabber_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en_i,
    input logic speed_10_i,
    input logic jab_off_i,
    input logic stat_rd_i,
    input logic tx_gate_o,
    input logic col_o,
    input logic jab_live_o,
    input logic jab_latched_o
);
    p_trip_needs_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab_live_o) |-> $past(tx_en_i));

    p_gate_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jab_live_o |-> !tx_gate_o);

    p_gate_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !jab_live_o |-> (tx_gate_o == tx_en_i));

    p_col_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        col_o == jab_live_o);

    p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab_live_o) |-> jab_latched_o);

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_latched_o && !stat_rd_i) |=> jab_latched_o);

    p_inert_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_10_i |=> !jab_live_o);

    p_inert_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jab_off_i |=> !jab_live_o);

    p_read_keeps_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_live_o && stat_rd_i && tx_en_i && speed_10_i && !jab_off_i) |=> jab_live_o);
endmodule

bind tx_jabber_guard tx_jabber_guard_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en_i       (tx_en_i),
    .speed_10_i    (speed_10_i),
    .jab_off_i     (jab_off_i),
    .stat_rd_i     (stat_rd_i),
    .tx_gate_o     (tx_gate_o),
    .col_o         (col_o),
    .jab_live_o    (jab_live_o),
    .jab_latched_o (jab_latched_o)
);

// File: tb/tx_jabber_guard_tb_top.sv
module tx_jabber_guard_tb_top;
    localparam int CLK_P = 10;
    localparam int LIM   = 8;
    localparam int REL   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, spd10 = 1'b1, joff = 1'b0, rd = 1'b0;
    logic gate, col, live, latched;
    int   n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    tx_jabber_guard #(.JAB_LIMIT_CYC(LIM), .RELEASE_CYC(REL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .speed_10_i(spd10),
        .jab_off_i(joff), .stat_rd_i(rd), .tx_gate_o(gate), .col_o(col),
        .jab_live_o(live), .jab_latched_o(latched)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // live, collision and gate together against an expected jabber state
    task automatic chk_jab(input logic exp_live, input string req);
        chk(live, exp_live, req);
        chk(col, exp_live, {req, "/R5 col"});
        chk(gate, tx_en & ~exp_live, {req, "/R4 gate"});
    endtask

    // drive low until released, checking R9 timing
    task automatic release_all();
        tx_en = 1'b0;
        for (int j = 1; j <= REL; j++) begin
            cyc();
            chk_jab(j < REL, "R9 release");
        end
    endtask

    task automatic clear_sticky();
        rd = 1'b1; cyc(); rd = 1'b0;
        chk(latched, 1'b0, "R6 read clears");
    endtask

    initial begin
        cyc(); cyc();
        chk(gate, 1'b0, "R1 gate"); chk(col, 1'b0, "R1 col");
        chk(live, 1'b0, "R1 live"); chk(latched, 1'b0, "R1 latched");
        rst_n = 1'b1;
        cyc(); cyc();
        chk(latched, 1'b0, "R1 latched after reset");
        chk(live, 1'b0, "R1 live after reset");

        // R2: burst-length sweep across the limit
        for (int n = 1; n <= LIM + 3; n++) begin
            tx_en = 1'b1;
            for (int i = 1; i <= n; i++) begin
                cyc();
                chk_jab(i > LIM, "R2 trip");
            end
            chk(latched, n > LIM, "R6 sticky after burst");
            if (n > LIM) begin
                release_all();
                chk(latched, 1'b1, "R6 sticky holds after release");
                clear_sticky();
            end else begin
                tx_en = 1'b0; cyc();
                chk_jab(1'b0, "R2 short burst");
            end
        end

        // R3: runs split by one low cycle do not add up
        for (int k = 0; k < 3; k++) begin
            tx_en = 1'b1;
            for (int i = 0; i < LIM; i++) cyc();
            chk_jab(1'b0, "R3 split run");
            tx_en = 1'b0; cyc();
        end
        chk(latched, 1'b0, "R3 no sticky");

        // R9: quiet-period interruptions at every position
        for (int p = 1; p < REL; p++) begin
            tx_en = 1'b1;
            for (int i = 0; i <= LIM; i++) cyc();
            chk_jab(1'b1, "R9 entered");
            tx_en = 1'b0;
            for (int j = 0; j < p; j++) cyc();
            tx_en = 1'b1; cyc();
            chk_jab(1'b1, "R9 restart high");
            release_all();
            clear_sticky();
        end

        // R6/R10: read on the trip edge, and reads while live
        tx_en = 1'b1;
        for (int i = 0; i < LIM; i++) cyc();
        rd = 1'b1; cyc();
        chk(latched, 1'b1, "R6 set beats read");
        chk_jab(1'b1, "R10 read on trip");
        cyc();
        chk(latched, 1'b0, "R6 read clears while live");
        chk_jab(1'b1, "R10 live under read");
        rd = 1'b0;
        release_all();

        // R7: 100 Mb/s mode
        spd10 = 1'b0; tx_en = 1'b1;
        for (int i = 0; i < LIM + 4; i++) cyc();
        chk_jab(1'b0, "R7 fast no jab");
        spd10 = 1'b1;
        for (int i = 1; i <= LIM + 1; i++) begin
            cyc();
            chk_jab(i > LIM, "R7 restart from zero");
        end
        spd10 = 1'b0; cyc();
        chk_jab(1'b0, "R7 fast ends jab");
        tx_en = 1'b0; spd10 = 1'b1; cyc();
        clear_sticky();

        // R8: disable input
        joff = 1'b1; tx_en = 1'b1;
        for (int i = 0; i < LIM + 4; i++) cyc();
        chk_jab(1'b0, "R8 disabled no jab");
        chk(latched, 1'b0, "R8 no sticky");
        joff = 1'b0;
        for (int i = 0; i <= LIM; i++) cyc();
        chk_jab(1'b1, "R8 enabled trips");
        joff = 1'b1; cyc();
        chk_jab(1'b0, "R8 disable ends jab");
        tx_en = 1'b0; joff = 1'b0; cyc();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule